// File: doc/BRIEF.md
# Shared Pad Isolation Sequencer

This block controls the low-power isolation of an I/O pad block that several PHY clients share. It holds a count of active users. A client sends an init request when it starts to use the pads and an exit request when it stops. Only the first user to arrive releases the pads from isolation. Only the last user to leave returns them to isolation. Every other request changes only the count.

A release or isolation walks through three control outputs in a fixed order: a core power-down bit, an early clamp bit and the main clamp bit. Consecutive steps are separated by a programmable wait that is counted in clock cycles. Requests are served one at a time, and client 0 has fixed priority. Each request ends with a one-cycle completion pulse for the client that issued it. A request that would take the count below zero, or above its ceiling, is refused and flagged.

Top module: `pad_iso_seq`

## Requirements
- R1: After reset, `core_down`, `clamp_early` and `clamp_en` are all 1, `busy`, `done` and `err` are 0, and the user count is zero.
- R2: An init request at user count zero first drops `clamp_en`, then drops `clamp_early`, then drops `core_down`. The outputs read {core_down,clamp_early,clamp_en} = 110, 100, 000 in turn.
- R3: An exit request at user count one first raises `core_down`, then raises `clamp_early`, then raises `clamp_en`. The outputs read 100, 110, 111 in turn.
- R4: Consecutive steps of one sequence are exactly CLK_PER_US*GAP_US cycles apart. GAP_US must lie between 100 and 200.
- R5: An init request at a nonzero count below MAX_USERS increments the count and leaves all three control bits unchanged.
- R6: An exit request at a count above one decrements the count and leaves all three control bits unchanged.
- R7: An exit request at count zero raises `err` together with its `done` pulse. It changes no control bit and leaves the count at zero, so a following init still runs the full release.
- R8: When several clients request in the same cycle, the lowest-numbered client is served first. The others are served afterwards, one at a time.
- R9: Each request produces exactly one `done` pulse, one cycle long, on its own client's bit, after its last control step. `busy` is 1 while a request is in service, including the cycle of its `done` pulse.
- R10: An init request at count MAX_USERS raises `err` with its `done` pulse. It leaves the count and the control bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | N_CLIENTS | Per-client init request. Held high until that client's `done` pulse. |
| exit_req | input | N_CLIENTS | Per-client exit request. Held high until that client's `done` pulse. |
| core_down | output | 1 | Core power-down control, 1 = powered down |
| clamp_early | output | 1 | Early clamp control, 1 = clamped |
| clamp_en | output | 1 | Main clamp control, 1 = clamped |
| busy | output | 1 | A request is in service |
| done | output | N_CLIENTS | One-cycle completion pulse, per client |
| err | output | N_CLIENTS | Refused request, underflow or count ceiling. Valid with `done`. |

## Verification
The bench builds the block with CLK_PER_US=1 and GAP_US=150. Each step gap is therefore 150 cycles, and a full release or isolation completes in a few hundred cycles while still using the mid-range gap value. MAX_USERS=3 makes the count ceiling reachable with only a few requests, so the refusal at the ceiling can be exercised next to the refusal at zero. With two clients, simultaneous requests from both test the fixed priority in both directions: one simultaneous pair at count zero and one that ends at count zero.

// File: rtl/pad_iso_pkg.sv
package pad_iso_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT1 = 2'd1,
    ST_WAIT2 = 2'd2,
    ST_ACK   = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_INIT = 2'd1,
    OP_EXIT = 2'd2
  } req_op_t;

  typedef struct packed {
    logic core_down;
    logic clamp_early;
    logic clamp_en;
  } iso_bits_t;

  localparam iso_bits_t ISO_ALL = 3'b111;

endpackage

// File: rtl/pad_iso_arb.sv
module pad_iso_arb
  import pad_iso_pkg::*;
#(
  parameter int N_CLIENTS = 2,
  parameter int IDX_W     = 1
) (
  input  logic [N_CLIENTS-1:0] init_req,
  input  logic [N_CLIENTS-1:0] exit_req,
  output logic                 valid,
  output logic [IDX_W-1:0]     idx,
  output req_op_t              op
);

  // Scan from the top index down so the lowest index wins.
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    op    = OP_NONE;
    for (int i = N_CLIENTS - 1; i >= 0; i--) begin
      if (init_req[i] || exit_req[i]) begin
        valid = 1'b1;
        idx   = IDX_W'(i);
        op    = init_req[i] ? OP_INIT : OP_EXIT;
      end
    end
  end

endmodule

// File: rtl/pad_iso_users.sv
module pad_iso_users #(
  parameter int MAX_USERS = 8,
  parameter int CNT_W     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic is_zero,
  output logic is_one,
  output logic is_max
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (inc && !is_max) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (dec && !is_zero) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign is_zero = (cnt_q == '0);
  assign is_one  = (cnt_q == CNT_W'(1));
  assign is_max  = (cnt_q == CNT_W'(MAX_USERS));

  // The sequencer must never ask for a step past either end of the count.
  assert_no_dec_at_zero_R7: assert property (@(posedge clk) disable iff (rst)
    dec |-> !is_zero);
  assert_no_inc_at_max_R10: assert property (@(posedge clk) disable iff (rst)
    inc |-> !is_max);
  assert_single_update_R9: assert property (@(posedge clk) disable iff (rst)
    !(inc && dec));

endmodule

// File: rtl/pad_iso_timer.sv
module pad_iso_timer #(
  parameter int GAP_CYC = 15000,
  parameter int TW      = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= TW'(GAP_CYC - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  // A wait in progress is never restarted.
  assert_no_reload_midway_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> !load);

endmodule

// File: rtl/pad_iso_seq.sv
module pad_iso_seq
  import pad_iso_pkg::*;
#(
  parameter int N_CLIENTS  = 2,
  parameter int MAX_USERS  = 8,
  parameter int CLK_PER_US = 100,
  parameter int GAP_US     = 150
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_CLIENTS-1:0] init_req,
  input  logic [N_CLIENTS-1:0] exit_req,
  output logic                 core_down,
  output logic                 clamp_early,
  output logic                 clamp_en,
  output logic                 busy,
  output logic [N_CLIENTS-1:0] done,
  output logic [N_CLIENTS-1:0] err
);

  localparam int IDX_W   = (N_CLIENTS > 1) ? $clog2(N_CLIENTS) : 1;
  localparam int CNT_W   = $clog2(MAX_USERS + 1);
  localparam int GAP_CYC = CLK_PER_US * GAP_US;
  localparam int TW      = $clog2(GAP_CYC + 1);

  seq_state_t           state_q;
  iso_bits_t            bits_q;
  logic                 release_q;
  logic [IDX_W-1:0]     cur_q;
  logic [N_CLIENTS-1:0] done_q;
  logic [N_CLIENTS-1:0] err_q;

  logic             arb_valid;
  logic [IDX_W-1:0] arb_idx;
  req_op_t          arb_op;
  logic             is_zero, is_one, is_max;
  logic             tmr_expired;
  logic             take, start_rel, start_iso, inc, dec, tmr_load;

  pad_iso_arb #(.N_CLIENTS(N_CLIENTS), .IDX_W(IDX_W)) u_arb (
    .init_req (init_req),
    .exit_req (exit_req),
    .valid    (arb_valid),
    .idx      (arb_idx),
    .op       (arb_op)
  );

  pad_iso_users #(.MAX_USERS(MAX_USERS), .CNT_W(CNT_W)) u_users (
    .clk     (clk),
    .rst     (rst),
    .inc     (inc),
    .dec     (dec),
    .is_zero (is_zero),
    .is_one  (is_one),
    .is_max  (is_max)
  );

  pad_iso_timer #(.GAP_CYC(GAP_CYC), .TW(TW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .expired (tmr_expired)
  );

  always_comb begin
    take      = (state_q == ST_IDLE) && arb_valid;
    start_rel = take && (arb_op == OP_INIT) && is_zero;
    start_iso = take && (arb_op == OP_EXIT) && is_one;
    inc       = take && (arb_op == OP_INIT) && !is_max;
    dec       = take && (arb_op == OP_EXIT) && !is_zero;
    tmr_load  = start_rel || start_iso || ((state_q == ST_WAIT1) && tmr_expired);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      bits_q    <= ISO_ALL;
      release_q <= 1'b0;
      cur_q     <= '0;
      done_q    <= '0;
      err_q     <= '0;
    end else begin
      done_q <= '0;
      err_q  <= '0;
      case (state_q)
        ST_IDLE: begin
          if (take) begin
            cur_q <= arb_idx;
            if (start_rel) begin
              release_q       <= 1'b1;
              bits_q.clamp_en <= 1'b0;
              state_q         <= ST_WAIT1;
            end else if (start_iso) begin
              release_q        <= 1'b0;
              bits_q.core_down <= 1'b1;
              state_q          <= ST_WAIT1;
            end else begin
              done_q[arb_idx] <= 1'b1;
              err_q[arb_idx]  <= (arb_op == OP_INIT) ? is_max : is_zero;
              state_q         <= ST_ACK;
            end
          end
        end
        ST_WAIT1: begin
          if (tmr_expired) begin
            bits_q.clamp_early <= !release_q;
            state_q            <= ST_WAIT2;
          end
        end
        ST_WAIT2: begin
          if (tmr_expired) begin
            if (release_q) bits_q.core_down <= 1'b0;
            else           bits_q.clamp_en  <= 1'b1;
            done_q[cur_q] <= 1'b1;
            state_q       <= ST_ACK;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign core_down   = bits_q.core_down;
  assign clamp_early = bits_q.clamp_early;
  assign clamp_en    = bits_q.clamp_en;
  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign err         = err_q;

  // ---- checks next to the sequencing logic ----
  iso_bits_t     prev_bits_q;
  logic [TW:0]   since_chg_q;
  logic          chg;

  assign chg = (bits_q != prev_bits_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_bits_q <= ISO_ALL;
      since_chg_q <= '0;
    end else begin
      prev_bits_q <= bits_q;
      if (chg) since_chg_q <= '0;
      else if (since_chg_q != {(TW+1){1'b1}}) since_chg_q <= since_chg_q + 1'b1;
    end
  end

  assert_release_last_core_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(core_down) |-> (!clamp_early && !clamp_en));
  assert_release_early_after_clamp_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(clamp_early) |-> (!clamp_en && core_down));
  assert_isolate_clamp_last_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(clamp_en) |-> (core_down && clamp_early));
  assert_isolate_early_after_core_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(clamp_early) |-> (core_down && !clamp_en));
  assert_step_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (chg && (state_q == ST_WAIT2 || state_q == ST_ACK)) |-> (since_chg_q == (TW+1)'(GAP_CYC - 1)));
  assert_count_only_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACK && $past(state_q) == ST_IDLE) |-> !chg);
  assert_err_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    (err & ~done) == '0);
  assert_done_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    (done != '0) |=> (done == '0));
  assert_done_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (done != '0) |-> busy);

endmodule

// File: tb/test_pad_iso_seq.sv
module test_pad_iso_seq;

  localparam int NC  = 2;
  localparam int MU  = 3;
  localparam int GAP = 150;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NC-1:0] init_req = '0;
  logic [NC-1:0] exit_req = '0;
  logic          core_down, clamp_early, clamp_en, busy;
  logic [NC-1:0] done, err;

  pad_iso_seq #(.N_CLIENTS(NC), .MAX_USERS(MU), .CLK_PER_US(1), .GAP_US(GAP)) i_pad_iso_seq (
    .clk(clk), .rst(rst), .init_req(init_req), .exit_req(exit_req),
    .core_down(core_down), .clamp_early(clamp_early), .clamp_en(clamp_en),
    .busy(busy), .done(done), .err(err)
  );

  always #5 clk = ~clk;

  typedef struct {
    int         client;
    bit         err;
    logic [2:0] bits;
    string      tag;
  } sb_item_t;

  typedef struct {
    logic [2:0] bits;
    bit         first;
    string      tag;
  } step_item_t;

  sb_item_t   sb_q[$];
  step_item_t step_q[$];

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int model_cnt = 0;
  logic [2:0] model_bits = 3'b111;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [2:0] outs();
    return {core_down, clamp_early, clamp_en};
  endfunction

  // Model: compute the expected result of a request and queue it.
  task automatic expect_req(input int c, input bit is_init, input string tag);
    sb_item_t it;
    step_item_t st;
    it.client = c; it.err = 0; it.tag = tag;
    if (is_init) begin
      if (model_cnt == 0) begin
        st.tag = "R2";
        st.first = 1; st.bits = 3'b110; step_q.push_back(st);
        st.first = 0; st.bits = 3'b100; step_q.push_back(st);
        st.bits = 3'b000; step_q.push_back(st);
        model_bits = 3'b000; model_cnt = 1;
      end else if (model_cnt == MU) it.err = 1;
      else model_cnt++;
    end else begin
      if (model_cnt == 0) it.err = 1;
      else if (model_cnt == 1) begin
        st.tag = "R3";
        st.first = 1; st.bits = 3'b100; step_q.push_back(st);
        st.first = 0; st.bits = 3'b110; step_q.push_back(st);
        st.bits = 3'b111; step_q.push_back(st);
        model_bits = 3'b111; model_cnt = 0;
      end else model_cnt--;
    end
    it.bits = model_bits;
    sb_q.push_back(it);
  endtask

  task automatic hold_req(input int c, input bit is_init);
    @(negedge clk);
    if (is_init) init_req[c] = 1'b1; else exit_req[c] = 1'b1;
    do @(negedge clk); while (!done[c]);
    init_req[c] = 1'b0; exit_req[c] = 1'b0;
  endtask

  task automatic do_req(input int c, input bit is_init, input string tag);
    expect_req(c, is_init, tag);
    hold_req(c, is_init);
  endtask

  // Monitor: completions and control-bit steps.
  logic [2:0]    last_bits = 3'b111;
  int            last_chg  = 0;
  logic [NC-1:0] prev_done = '0;

  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (done != '0) begin
        sb_item_t it;
        checks++;
        if (sb_q.size() == 0) begin
          fails++;
          $display("FAIL R9: unexpected done=%b expected none", done);
        end else begin
          it = sb_q.pop_front();
          if (done != NC'(1 << it.client) || err != (it.err ? NC'(1 << it.client) : NC'(0))
              || outs() != it.bits || !busy) begin
            fails++;
            $display("FAIL %s: done=%b err=%b bits=%b busy=%b expected done=%b err=%0d bits=%b busy=1",
                     it.tag, done, err, outs(), busy, NC'(1 << it.client), it.err, it.bits);
          end
        end
        if (prev_done != '0) begin
          fails++;
          $display("FAIL R9: done held two cycles, now %b expected 0", done);
        end
      end
      prev_done = done;
      if (outs() != last_bits) begin
        step_item_t st;
        checks++;
        if (step_q.size() == 0) begin
          fails++;
          $display("FAIL R5/R6: control bits changed to %b expected %b", outs(), last_bits);
        end else begin
          st = step_q.pop_front();
          if (outs() != st.bits) begin
            fails++;
            $display("FAIL %s: step bits %b expected %b", st.tag, outs(), st.bits);
          end
          if (!st.first && (cyc - last_chg) != GAP) begin
            fails++;
            $display("FAIL R4: step gap %0d expected %0d", cyc - last_chg, GAP);
          end
        end
        last_bits = outs();
        last_chg  = cyc;
      end
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run still active, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    checks++;
    if (outs() != 3'b111 || busy || done != '0 || err != '0) begin
      fails++;
      $display("FAIL R1: bits=%b busy=%b done=%b err=%b expected 111 0 0 0", outs(), busy, done, err);
    end
    do_req(0, 0, "R7");  // underflow at zero
    do_req(0, 1, "R2");  // release, also R4, and R7 count stayed zero
    do_req(1, 1, "R5");  // count 2
    do_req(1, 1, "R5");  // count 3
    do_req(0, 1, "R10"); // ceiling refused
    do_req(0, 0, "R6");  // 3 -> 2
    do_req(1, 0, "R6");  // 2 -> 1
    do_req(1, 0, "R3");  // isolate
    do_req(1, 0, "R7");  // underflow again
    // R8: simultaneous init, client 0 served first
    expect_req(0, 1, "R8");
    expect_req(1, 1, "R8");
    fork hold_req(0, 1); hold_req(1, 1); join
    // R8: simultaneous exit, client 0 decrements, client 1 isolates
    expect_req(0, 0, "R8");
    expect_req(1, 0, "R8");
    fork hold_req(0, 0); hold_req(1, 0); join
    repeat (5) @(negedge clk);
    checks++;
    if (sb_q.size() != 0 || step_q.size() != 0 || busy) begin
      fails++;
      $display("FAIL R9: pending=%0d steps=%0d busy=%b expected 0 0 0", sb_q.size(), step_q.size(), busy);
    end
    finish_run();
  end

endmodule